// File: doc/BRIEF.md
# Wave-Ordered Memory Request Sequencer

This block sits between a fabric of dataflow processing elements and a small data memory. Loads and stores can arrive in any order. Each one carries a wave number, its own sequence number inside that wave, and the sequence numbers of the operations just before and just after it in program order. The sequencer parks requests in an eight-entry buffer. It hands one to memory only when the links show that the request is the next operation in program order. This keeps ordinary sequential load/store meaning without a single program counter.

Waves retire one after another. Sequence value 15 (all ones) is reserved. In the predecessor field it means "first operation of the wave". In the successor field it means "last operation of the wave". Issuing a last operation moves the sequencer on to the next wave number, which wraps modulo 16. A load returns its data on a response stream, tagged with its wave and sequence numbers. A store returns nothing.

Both data interfaces are valid/ready. A request transfers on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` drops while all buffer entries are occupied. A response transfers on a rising edge where `rsp_valid` and `rsp_ready` are both high. While a response waits, its fields do not change. No further load issues until the response slot frees, but stores keep issuing.

Top module: `wave_mem_sequencer`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, and every memory word reads as 0.
- R2: Inside the current wave, a request whose predecessor field is 15 issues first. After that, a request issues only when its predecessor field equals the sequence number issued last. At most one request issues per cycle.
- R3: Waves issue in increasing wave-number order, modulo 16. A request of a later wave stays buffered until the request with successor field 15 of the current wave has issued, even if it arrived earlier.
- R4: A load returns the value of the most recent store to the same address that precedes it in wave/sequence order, whatever the arrival order.
- R5: The buffer holds 8 requests. `req_ready` is 0 while all 8 entries are occupied, and a request offered then is not taken.
- R6: A load response carries the load's wave number, sequence number and read data. A load accepted on edge E, with its predecessor already issued, issues on the next edge, and `rsp_valid` is high right after that edge.
- R7: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_wave`, `rsp_seq` and `rsp_data` hold their values.
- R8: Each load produces exactly one response, and a store produces none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Buffer has a free entry |
| req_wave | input | 4 | Wave number of the request |
| req_seq | input | 4 | Sequence number within the wave |
| req_pred | input | 4 | Predecessor sequence number; 15 means first of the wave |
| req_succ | input | 4 | Successor sequence number; 15 means last of the wave |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | 4 | Word address |
| req_wdata | input | 16 | Store data |
| rsp_valid | output | 1 | Load response available |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_wave | output | 4 | Wave number of the answered load |
| rsp_seq | output | 4 | Sequence number of the answered load |
| rsp_data | output | 16 | Loaded word |

## Verification
A load whose chain is already complete issues on the first edge after the edge that accepts it. Its response is visible from the falling edge that follows, so the bench probes `rsp_valid` low one half cycle after acceptance and high one cycle later. All driving and sampling happen on falling edges. Responses are matched in order against a list of expected wave, sequence and data values. The bench builds that list arithmetically before it sends the stimulus. The list covers all 24 arrival orders of a four-operation store/load wave, a later wave that arrives early, and a fill of the buffer. Held responses are compared with their first-seen value on every stalled cycle.

// File: rtl/wms_pkg.sv
package wms_pkg;
  localparam int WAVE_W = 4;
  localparam int SEQ_W  = 4;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 16;
  localparam logic [SEQ_W-1:0] SEQ_NONE = '1;

  typedef struct packed {
    logic [WAVE_W-1:0] wave;
    logic [SEQ_W-1:0]  seq;
    logic [SEQ_W-1:0]  pred;
    logic [SEQ_W-1:0]  succ;
    logic              is_store;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
  } mreq_t;
endpackage

// File: rtl/wms_tracker.sv
module wms_tracker
  import wms_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_fire,
  input  mreq_t             iss_req,
  output logic [WAVE_W-1:0] cur_wave,
  output logic              started,
  output logic [SEQ_W-1:0]  last_seq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_wave <= '0;
      started  <= 1'b0;
      last_seq <= '0;
    end else if (iss_fire) begin
      if (iss_req.succ == SEQ_NONE) begin
        cur_wave <= cur_wave + 1'b1;
        started  <= 1'b0;
        last_seq <= '0;
      end else begin
        started  <= 1'b1;
        last_seq <= iss_req.seq;
      end
    end
  end

  // R2
  chain_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_fire && started |-> iss_req.pred == last_seq && iss_req.wave == cur_wave);

  // R3
  wave_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_fire && iss_req.succ == SEQ_NONE |=> !started && cur_wave == WAVE_W'($past(cur_wave) + 1'b1));
endmodule

// File: rtl/wms_buffer.sv
module wms_buffer
  import wms_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  mreq_t             in_req,
  output logic              in_ready,
  input  logic [WAVE_W-1:0] cur_wave,
  input  logic              started,
  input  logic [SEQ_W-1:0]  last_seq,
  input  logic              load_ok,
  output logic              iss_fire,
  output mreq_t             iss_req
);
  logic [DEPTH-1:0] occ, elig, grant, alloc;
  mreq_t            ent [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic link_ok;
    assign link_ok = started ? (ent[g].pred == last_seq && ent[g].pred != SEQ_NONE)
                             : (ent[g].pred == SEQ_NONE);
    assign elig[g] = occ[g] && ent[g].wave == cur_wave && link_ok
                     && (ent[g].is_store || load_ok);
  end

  always_comb begin
    grant = '0;
    alloc = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (elig[i] && grant == '0) grant[i] = 1'b1;
      if (!occ[i] && alloc == '0) alloc[i] = 1'b1;
    end
  end

  always_comb begin
    iss_req = '0;
    for (int i = 0; i < DEPTH; i++)
      if (grant[i]) iss_req = ent[i];
  end

  assign iss_fire = |grant;
  assign in_ready = ~&occ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (grant[i]) occ[i] <= 1'b0;
        if (alloc[i] && in_valid && in_ready) begin
          occ[i] <= 1'b1;
          ent[i] <= in_req;
        end
      end
    end
  end

  // R2
  one_issue_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_ready |=> (occ & ~$past(occ)) == '0);
endmodule

// File: rtl/wms_store.sv
module wms_store
  import wms_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  mreq_t             acc_req,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [WAVE_W-1:0] rsp_wave,
  output logic [SEQ_W-1:0]  rsp_seq,
  output logic [DATA_W-1:0] rsp_data,
  output logic              slot_free
);
  localparam int WORDS = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [WORDS];

  assign slot_free = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
      rsp_valid <= 1'b0;
      rsp_wave  <= '0;
      rsp_seq   <= '0;
      rsp_data  <= '0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      if (acc_en) begin
        if (acc_req.is_store) begin
          mem[acc_req.addr] <= acc_req.wdata;
        end else begin
          rsp_valid <= 1'b1;
          rsp_wave  <= acc_req.wave;
          rsp_seq   <= acc_req.seq;
          rsp_data  <= mem[acc_req.addr];
        end
      end
    end
  end

  // R7
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_seq) && $stable(rsp_wave));

  // R6
  load_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en && !acc_req.is_store |=> rsp_valid && rsp_seq == $past(acc_req.seq));
endmodule

// File: rtl/wave_mem_sequencer.sv
module wave_mem_sequencer
  import wms_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [WAVE_W-1:0] req_wave,
  input  logic [SEQ_W-1:0]  req_seq,
  input  logic [SEQ_W-1:0]  req_pred,
  input  logic [SEQ_W-1:0]  req_succ,
  input  logic              req_store,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WAVE_W-1:0] rsp_wave,
  output logic [SEQ_W-1:0]  rsp_seq,
  output logic [DATA_W-1:0] rsp_data
);
  mreq_t             in_req, iss_req;
  logic              iss_fire, started, slot_free;
  logic [WAVE_W-1:0] cur_wave;
  logic [SEQ_W-1:0]  last_seq;

  assign in_req = '{wave: req_wave, seq: req_seq, pred: req_pred, succ: req_succ,
                    is_store: req_store, addr: req_addr, wdata: req_wdata};

  wms_buffer #(.DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .in_valid(req_valid), .in_req(in_req), .in_ready(req_ready),
    .cur_wave(cur_wave), .started(started), .last_seq(last_seq), .load_ok(slot_free),
    .iss_fire(iss_fire), .iss_req(iss_req)
  );

  wms_tracker u_trk (
    .clk(clk), .rst_n(rst_n), .iss_fire(iss_fire), .iss_req(iss_req),
    .cur_wave(cur_wave), .started(started), .last_seq(last_seq)
  );

  wms_store u_mem (
    .clk(clk), .rst_n(rst_n), .acc_en(iss_fire), .acc_req(iss_req), .rsp_ready(rsp_ready),
    .rsp_valid(rsp_valid), .rsp_wave(rsp_wave), .rsp_seq(rsp_seq), .rsp_data(rsp_data),
    .slot_free(slot_free)
  );

  // R8
  store_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_fire && iss_req.is_store && !(rsp_valid && !rsp_ready) |=> !rsp_valid);
endmodule

// File: tb/wave_mem_sequencer_tb.sv
module wave_mem_sequencer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready, req_store = 1'b0;
  logic [3:0]  req_wave = '0, req_seq = '0, req_pred = '0, req_succ = '0, req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid, rsp_ready = 1'b1;
  logic [3:0]  rsp_wave, rsp_seq;
  logic [15:0] rsp_data;

  localparam logic [3:0] NONE = 4'hF;

  wave_mem_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_wave(req_wave), .req_seq(req_seq), .req_pred(req_pred), .req_succ(req_succ),
    .req_store(req_store), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_wave(rsp_wave),
    .rsp_seq(rsp_seq), .rsp_data(rsp_data)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0, wr = 0, rd = 0, nloads = 0, stall_cnt = 0;
  bit stall_mode = 1'b0;
  logic [3:0]  exp_w [64];
  logic [3:0]  exp_s [64];
  logic [15:0] exp_d [64];
  string       exp_t [64];
  logic [15:0] hold_d;
  logic [3:0]  hold_s;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic expect_rsp(input logic [3:0] w, input logic [3:0] s, input logic [15:0] d, input string t);
    exp_w[wr] = w; exp_s[wr] = s; exp_d[wr] = d; exp_t[wr] = t;
    wr++;
  endtask

  task automatic send(input logic [3:0] w, input logic [3:0] s, input logic [3:0] p, input logic [3:0] n,
                      input bit st, input logic [3:0] a, input logic [15:0] d);
    req_valid = 1'b1; req_wave = w; req_seq = s; req_pred = p; req_succ = n;
    req_store = st; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (!st) nloads++;
  endtask

  task automatic drain();
    while (rd != wr) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // response monitor: consumes, stalls and compares in order
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (stall_mode && stall_cnt < 3) begin
        if (stall_cnt == 0) begin
          hold_d = rsp_data; hold_s = rsp_seq;
        end else begin
          chk(rsp_data == hold_d && rsp_seq == hold_s, "R7", "held response data", int'(rsp_data), int'(hold_d));
        end
        stall_cnt++;
        rsp_ready = 1'b0;
      end else begin
        rsp_ready = 1'b1;
        stall_cnt = 0;
        if (rd >= wr) begin
          chk(1'b0, "R8", "unexpected response seq", int'(rsp_seq), -1);
        end else begin
          chk(rsp_wave == exp_w[rd], exp_t[rd], "response wave", int'(rsp_wave), int'(exp_w[rd]));
          chk(rsp_seq == exp_s[rd], exp_t[rd], "response seq", int'(rsp_seq), int'(exp_s[rd]));
          chk(rsp_data == exp_d[rd], exp_t[rd], "response data", int'(rsp_data), int'(exp_d[rd]));
          rd++;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    finish_run();
  end

  initial begin
    int w;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready in reset", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", int'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R6: single-op wave, load of an untouched word, latency probe
    expect_rsp(4'd0, 4'd0, 16'd0, "R1");
    send(4'd0, 4'd0, NONE, NONE, 1'b0, 4'd3, 16'd0);
    chk(rsp_valid == 1'b0, "R6", "rsp_valid right after accept", int'(rsp_valid), 0);
    @(negedge clk);
    chk(rsp_valid == 1'b1, "R6", "rsp_valid one cycle later", int'(rsp_valid), 1);
    drain();
    w = 1;

    // R2 / R4: every arrival order of store, load, store, load on one address
    for (int k = 0; k < 24; k++) begin
      int avail[4];
      int perm[4];
      int idx;
      logic [3:0] wv, a;
      logic [15:0] v1, v2;
      for (int i = 0; i < 4; i++) avail[i] = i;
      idx = k;
      for (int i = 0; i < 4; i++) begin
        int f, j;
        f = (i == 0) ? 6 : (i == 1) ? 2 : 1;
        j = idx / f;
        idx = idx % f;
        perm[i] = avail[j];
        for (int m = j; m < 3 - i; m++) avail[m] = avail[m + 1];
      end
      wv = 4'(w);
      a  = 4'(k);
      v1 = 16'(k * 37 + 11);
      v2 = 16'(k * 53 + 700);
      stall_mode = k[0];
      expect_rsp(wv, 4'd1, v1, "R4");
      expect_rsp(wv, 4'd3, v2, "R2");
      for (int i = 0; i < 4; i++) begin
        logic [3:0] s;
        s = 4'(perm[i]);
        send(wv, s, (s == 0) ? NONE : s - 1'b1, (s == 3) ? NONE : s + 1'b1,
             (s == 0 || s == 2), a, (s == 0) ? v1 : ((s == 2) ? v2 : 16'd0));
      end
      drain();
      w++;
    end
    stall_mode = 1'b0;

    // R3: a later wave arrives first and must wait
    begin
      int rd0;
      expect_rsp(4'(w), 4'd1, 16'hBEEF, "R3");
      expect_rsp(4'(w + 1), 4'd0, 16'hBEEF, "R3");
      rd0 = rd;
      send(4'(w + 1), 4'd0, NONE, NONE, 1'b0, 4'd7, 16'd0);
      repeat (6) @(negedge clk);
      chk(rsp_valid == 1'b0 && rd == rd0, "R3", "later wave held, rsp_valid", int'(rsp_valid), 0);
      send(4'(w), 4'd0, NONE, 4'd1, 1'b1, 4'd7, 16'hBEEF);
      send(4'(w), 4'd1, 4'd0, NONE, 1'b0, 4'd7, 16'd0);
      drain();
      w += 2;
    end

    // R5: seven blocked loads plus their store fill the buffer
    for (int s = 1; s < 8; s++) expect_rsp(4'(w), 4'(s), 16'h1234, "R5");
    for (int s = 1; s < 8; s++)
      send(4'(w), 4'(s), 4'(s - 1), (s == 7) ? NONE : 4'(s + 1), 1'b0, 4'd9, 16'd0);
    send(4'(w), 4'd0, NONE, 4'd1, 1'b1, 4'd9, 16'h1234);
    chk(req_ready == 1'b0, "R5", "req_ready with 8 entries", int'(req_ready), 0);
    drain();

    // R8: one response per load, none for stores
    repeat (5) @(negedge clk);
    chk(rsp_valid == 1'b0, "R8", "rsp_valid after drain", int'(rsp_valid), 0);
    chk(rd == nloads, "R8", "response count", rd, nloads);
    finish_run();
  end
endmodule